// File: doc/BRIEF.md
# Mode-Switched ROM/RAM Bank Controller

This block decodes CPU writes into the ROM address range as control-register writes for a cartridge-style banked memory system. An 8-bit CPU with a 16-bit address bus sees two 16 KiB ROM windows and one 8 KiB external RAM window. The controller holds a RAM enable, a five-bit low ROM bank field, one shared two-bit field and a mode bit. From these it produces the physical ROM and RAM address bits, a RAM write strobe and the CPU read data.

The shared two-bit field is steered by the mode bit. In mode 0 it supplies ROM bank bits [6:5]. In mode 1 it selects one of four RAM banks. Bank numbers that lie past the fitted ROM are folded back into range, and a bank that ends up as zero is replaced by one. A separate combinational decoder turns the cartridge header's RAM-size code into a byte count.

The block has no streaming data path. Every port is a plain level or strobe. Register writes take effect at the clock edge on which `cpu_wr` is sampled high. Address and read-data outputs are combinational from the current address and the registered state, so there is no back-pressure to manage.

Top module: `bank_mode_ctrl`

## Requirements
- R1: After reset, `ram_en`=0, `rom_bank`=1, `ram_bank`=0 and `mode`=0.
- R2: A write with `cpu_addr[15:13]`=3'b000 and data 8'h0A sets `ram_en`. Data 8'h00 clears it. Any other data leaves it unchanged.
- R3: A write with `cpu_addr[15:13]`=3'b001 loads data bits [4:0] into ROM bank bits [4:0] and keeps bits [6:5]. A written value of zero in bits [4:0] is stored as 1.
- R4: A write with `cpu_addr[15:13]`=3'b010 uses only data bits [1:0]. In mode 0 they become ROM bank bits [6:5]. In mode 1 they become `ram_bank`, and ROM bank bits [6:5] stay unchanged.
- R5: A write with `cpu_addr[15:13]`=3'b011 sets `mode` to data bit 0. Writing 1 clears ROM bank bits [6:5]. Writing 0 forces `ram_bank` to 0.
- R6: When the raw bank {bits[6:5], bits[4:0]} is at least ROM_BANKS, `rom_bank` is the raw bank AND (ROM_BANKS-1). If that result is zero, `rom_bank` is 1. An in-range raw bank passes through unchanged.
- R7: `ram_size` decodes `hdr_ram_code` as follows: 0→0, 1→2048, 2→8192, 3→32768, and any other code→8192.
- R8: For CPU addresses 0x0000–0x3FFF, `rom_addr`={0, addr[13:0]}. For 0x4000–0x7FFF, `rom_addr`={rom_bank[IDX_W-1:0], addr[13:0]}. For any address below 0x8000, `cpu_rdata`=`rom_rdata`.
- R9: In the window 0xA000–0xBFFF, `ram_addr`={ram_bank, addr[12:0]}. `ram_we` is 1 only when `cpu_wr` and `ram_en` are both high. Reads return `ram_rdata` while enabled and 8'hFF while disabled.
- R10: Writes at addresses 0x8000 and above leave all control registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| rom_rdata | input | 8 | Data from the ROM array |
| ram_rdata | input | 8 | Data from the RAM array |
| hdr_ram_code | input | 8 | RAM-size code from the cartridge header |
| ram_en | output | 1 | External RAM enabled |
| mode | output | 1 | Routing mode of the shared field |
| rom_bank | output | 7 | Effective switchable ROM bank |
| ram_bank | output | 2 | Selected RAM bank |
| rom_addr | output | ROM_AW | Physical ROM address |
| ram_addr | output | 15 | Physical RAM address |
| ram_we | output | 1 | RAM write strobe |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| ram_size | output | 16 | Decoded RAM size in bytes |

## Verification
Register effects (R1–R6, R10) appear one cycle after a write. The write strobe is raised on a falling edge and sampled at the following rising edge. The bank, enable and mode outputs are therefore checked just after the next falling edge. The address map, read-data mux, write strobe and size decoder (R7–R9) are combinational, so they are checked 1 ns after their inputs change, with no clock edge in between. A second instance with eight banks exposes the case where masking drives the bank to zero.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

  // Control-register region, chosen by CPU address bits [14:13] below 0x8000
  typedef enum logic [1:0] {
    SEL_RAMEN  = 2'd0,
    SEL_LOBANK = 2'd1,
    SEL_SHARED = 2'd2,
    SEL_MODE   = 2'd3
  } reg_sel_e;

  localparam int LO_W    = 5;
  localparam int HI_W    = 2;
  localparam int BANK_W  = LO_W + HI_W;
  localparam int WIN_W   = 14;   // 16 KiB ROM window
  localparam int RWIN_W  = 13;   // 8 KiB RAM window

  localparam logic [7:0] KEY_ON  = 8'h0A;
  localparam logic [7:0] KEY_OFF = 8'h00;

  function automatic logic [15:0] ram_bytes(input logic [7:0] code);
    case (code)
      8'd0:    ram_bytes = 16'h0000;
      8'd1:    ram_bytes = 16'h0800;
      8'd3:    ram_bytes = 16'h8000;
      default: ram_bytes = 16'h2000;
    endcase
  endfunction

endpackage

// File: rtl/bmc_regs.sv
module bmc_regs
  import bmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [2:0]        region,
  input  logic [7:0]        wdata,
  output logic              ram_en,
  output logic [LO_W-1:0]   lo_bank,
  output logic [HI_W-1:0]   hi_bank,
  output logic [HI_W-1:0]   ram_bank,
  output logic              mode
);

  logic     reg_hit;
  reg_sel_e sel;

  assign reg_hit = wr && !region[2];
  assign sel     = reg_sel_e'(region[1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_en   <= 1'b0;
      lo_bank  <= LO_W'(1);
      hi_bank  <= '0;
      ram_bank <= '0;
      mode     <= 1'b0;
    end else if (reg_hit) begin
      case (sel)
        SEL_RAMEN: begin
          if (wdata == KEY_ON)       ram_en <= 1'b1;
          else if (wdata == KEY_OFF) ram_en <= 1'b0;
        end
        SEL_LOBANK: begin
          if (wdata[LO_W-1:0] == '0) lo_bank <= LO_W'(1);
          else                       lo_bank <= wdata[LO_W-1:0];
        end
        SEL_SHARED: begin
          if (mode) ram_bank <= wdata[HI_W-1:0];
          else      hi_bank  <= wdata[HI_W-1:0];
        end
        default: begin
          mode <= wdata[0];
          if (wdata[0]) hi_bank  <= '0;
          else          ram_bank <= '0;
        end
      endcase
    end
  end

  // R2
  ram_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && region == 3'd0 && wdata == KEY_ON) |=> ram_en);

  // R2
  ram_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && region == 3'd0 && wdata != KEY_ON && wdata != KEY_OFF) |=> $stable(ram_en));

  // R3
  lo_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && region == 3'd1 && wdata[LO_W-1:0] == '0) |=> lo_bank == LO_W'(1));

  // R4
  shared_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && region == 3'd2 && mode) |=> ($stable(hi_bank) && ram_bank == $past(wdata[HI_W-1:0])));

  // R5
  mode_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && region == 3'd3 && wdata[0]) |=> (mode && hi_bank == '0));

  // R5
  mode_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && region == 3'd3 && !wdata[0]) |=> (!mode && ram_bank == '0));

  // R10
  high_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && region[2]) |=> ($stable(lo_bank) && $stable(hi_bank) && $stable(ram_en) && $stable(mode)));

endmodule

// File: rtl/bmc_bank_map.sv
module bmc_bank_map
  import bmc_pkg::*;
#(
  parameter int ROM_BANKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] raw,
  output logic [BANK_W-1:0] eff
);

  localparam logic [BANK_W-1:0] MASK = BANK_W'(ROM_BANKS - 1);

  logic              over;
  logic [BANK_W-1:0] folded;

  assign over = int'(raw) >= ROM_BANKS;

  always_comb begin
    folded = over ? (raw & MASK) : raw;
    eff    = (folded == '0) ? BANK_W'(1) : folded;
  end

  // R6
  eff_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eff != '0) && (int'(eff) < ROM_BANKS));

  // R6
  eff_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(raw) < ROM_BANKS && raw != '0) |-> eff == raw);

endmodule

// File: rtl/bmc_addr_map.sv
module bmc_addr_map
  import bmc_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [15:0]            addr,
  input  logic                   wr,
  input  logic [IDX_W-1:0]       bank_idx,
  input  logic [HI_W-1:0]        ram_bank,
  input  logic                   ram_en,
  input  logic [7:0]             rom_rdata,
  input  logic [7:0]             ram_rdata,
  output logic [IDX_W+WIN_W-1:0] rom_addr,
  output logic [HI_W+RWIN_W-1:0] ram_addr,
  output logic                   ram_we,
  output logic [7:0]             cpu_rdata
);

  logic in_ram;

  assign in_ram   = (addr[15:13] == 3'b101);
  assign rom_addr = addr[14] ? {bank_idx, addr[WIN_W-1:0]}
                             : {{IDX_W{1'b0}}, addr[WIN_W-1:0]};
  assign ram_addr = {ram_bank, addr[RWIN_W-1:0]};
  assign ram_we   = wr && in_ram && ram_en;

  always_comb begin
    if (!addr[15])   cpu_rdata = rom_rdata;
    else if (in_ram) cpu_rdata = ram_en ? ram_rdata : 8'hFF;
    else             cpu_rdata = 8'hFF;
  end

  // R9
  ram_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ram && !ram_en) |-> cpu_rdata == 8'hFF);

  // R9
  ram_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_en && wr));

  // R8
  fixed_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[15:14] == 2'b00) |-> rom_addr[IDX_W+WIN_W-1:WIN_W] == '0);

endmodule

// File: rtl/bank_mode_ctrl.sv
module bank_mode_ctrl
  import bmc_pkg::*;
#(
  parameter int ROM_BANKS = 64,
  localparam int IDX_W    = $clog2(ROM_BANKS),
  localparam int ROM_AW   = IDX_W + WIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic [7:0]        rom_rdata,
  input  logic [7:0]        ram_rdata,
  input  logic [7:0]        hdr_ram_code,
  output logic              ram_en,
  output logic              mode,
  output logic [BANK_W-1:0] rom_bank,
  output logic [HI_W-1:0]   ram_bank,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [14:0]       ram_addr,
  output logic              ram_we,
  output logic [7:0]        cpu_rdata,
  output logic [15:0]       ram_size
);

  logic [LO_W-1:0] lo_bank;
  logic [HI_W-1:0] hi_bank;

  bmc_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cpu_wr),
    .region   (cpu_addr[15:13]),
    .wdata    (cpu_wdata),
    .ram_en   (ram_en),
    .lo_bank  (lo_bank),
    .hi_bank  (hi_bank),
    .ram_bank (ram_bank),
    .mode     (mode)
  );

  bmc_bank_map #(.ROM_BANKS(ROM_BANKS)) u_map (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   ({hi_bank, lo_bank}),
    .eff   (rom_bank)
  );

  bmc_addr_map #(.IDX_W(IDX_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (cpu_addr),
    .wr        (cpu_wr),
    .bank_idx  (rom_bank[IDX_W-1:0]),
    .ram_bank  (ram_bank),
    .ram_en    (ram_en),
    .rom_rdata (rom_rdata),
    .ram_rdata (ram_rdata),
    .rom_addr  (rom_addr),
    .ram_addr  (ram_addr),
    .ram_we    (ram_we),
    .cpu_rdata (cpu_rdata)
  );

  assign ram_size = ram_bytes(hdr_ram_code);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (!ram_en && !mode && rom_bank == BANK_W'(1) && ram_bank == '0));

endmodule

// File: tb/sim_bank_mode_ctrl.sv
module sim_bank_mode_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  rom_rdata = 8'h3C;
  logic [7:0]  ram_rdata = 8'h77;
  logic [7:0]  hdr_ram_code = '0;

  logic        ram_en, mode, ram_we;
  logic [6:0]  rom_bank;
  logic [1:0]  ram_bank;
  logic [19:0] rom_addr;
  logic [14:0] ram_addr;
  logic [7:0]  cpu_rdata;
  logic [15:0] ram_size;

  logic        e1, m1, we1;
  logic [6:0]  rb1;
  logic [1:0]  kb1;
  logic [16:0] ra1;
  logic [14:0] qa1;
  logic [7:0]  cd1;
  logic [15:0] rs1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bank_mode_ctrl #(.ROM_BANKS(64)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .rom_rdata(rom_rdata), .ram_rdata(ram_rdata),
    .hdr_ram_code(hdr_ram_code), .ram_en(ram_en), .mode(mode),
    .rom_bank(rom_bank), .ram_bank(ram_bank), .rom_addr(rom_addr),
    .ram_addr(ram_addr), .ram_we(ram_we), .cpu_rdata(cpu_rdata),
    .ram_size(ram_size)
  );

  bank_mode_ctrl #(.ROM_BANKS(8)) u1 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .rom_rdata(rom_rdata), .ram_rdata(ram_rdata),
    .hdr_ram_code(hdr_ram_code), .ram_en(e1), .mode(m1),
    .rom_bank(rb1), .ram_bank(kb1), .rom_addr(ra1),
    .ram_addr(qa1), .ram_we(we1), .cpu_rdata(cd1),
    .ram_size(rs1)
  );

  // {addr16, data8, exp_bank7, exp_ram_bank2, exp_en1, exp_mode1}
  localparam int NV = 15;
  localparam logic [34:0] VEC [NV] = '{
    {16'h0000, 8'h0A, 7'h01, 2'd0, 1'b1, 1'b0},  // R2 enable
    {16'h1234, 8'h05, 7'h01, 2'd0, 1'b1, 1'b0},  // R2 other value ignored
    {16'h2000, 8'h1F, 7'h1F, 2'd0, 1'b1, 1'b0},  // R3
    {16'h3FFF, 8'h00, 7'h01, 2'd0, 1'b1, 1'b0},  // R3 zero -> 1
    {16'h2100, 8'hE3, 7'h03, 2'd0, 1'b1, 1'b0},  // R3 only [4:0]
    {16'h4000, 8'h01, 7'h23, 2'd0, 1'b1, 1'b0},  // R4 mode 0 upper bits
    {16'h2000, 8'h05, 7'h25, 2'd0, 1'b1, 1'b0},  // R3 keeps [6:5]
    {16'h4000, 8'hFE, 7'h05, 2'd0, 1'b1, 1'b0},  // R6 0x45 folded
    {16'h6000, 8'h01, 7'h05, 2'd0, 1'b1, 1'b1},  // R5 mode 1
    {16'h5000, 8'h03, 7'h05, 2'd3, 1'b1, 1'b1},  // R4 mode 1 RAM bank
    {16'h6000, 8'h00, 7'h05, 2'd0, 1'b1, 1'b0},  // R5 mode 0
    {16'h4000, 8'h01, 7'h25, 2'd0, 1'b1, 1'b0},  // R4
    {16'h8000, 8'h00, 7'h25, 2'd0, 1'b1, 1'b0},  // R10
    {16'hA000, 8'h00, 7'h25, 2'd0, 1'b1, 1'b0},  // R10
    {16'h0000, 8'h00, 7'h25, 2'd0, 1'b0, 1'b0}   // R2 disable
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr  = a;
    cpu_wdata = d;
    cpu_wr    = 1'b1;
    @(negedge clk);
    cpu_wr    = 1'b0;
    #1;
  endtask

  task automatic peek(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 ram_en", ram_en, 0);
    check("R1 rom_bank", rom_bank, 1);
    check("R1 ram_bank", ram_bank, 0);
    check("R1 mode", mode, 0);

    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][34:19], VEC[i][18:11]);
      check($sformatf("R2-R6/R10 vec%0d rom_bank", i), rom_bank, VEC[i][10:4]);
      check($sformatf("R4/R5 vec%0d ram_bank", i), ram_bank, VEC[i][3:2]);
      check($sformatf("R2 vec%0d ram_en", i), ram_en, VEC[i][1]);
      check($sformatf("R5 vec%0d mode", i), mode, VEC[i][0]);
    end

    // R6 small ROM: 0x25 folds to 5; 0x28 folds to 0 -> 1
    check("R6 u1 fold", rb1, 7'h05);
    do_write(16'h2000, 8'h08);
    check("R6 u0 in range", rom_bank, 7'h28);
    check("R6 u1 zero->1", rb1, 7'h01);

    // R8 ROM address map
    peek(16'h1234);
    check("R8 fixed window", rom_addr, 20'h01234);
    check("R8 rom read", cpu_rdata, 8'h3C);
    peek(16'h5678);
    check("R8 switched window", rom_addr, 20'hA1678);

    // R9 RAM window while disabled
    peek(16'hA123);
    check("R9 closed read", cpu_rdata, 8'hFF);
    cpu_wr = 1'b1; #1;
    check("R9 closed we", ram_we, 0);
    cpu_wr = 1'b0;
    do_write(16'h0000, 8'h0A);
    do_write(16'h6000, 8'h01);
    do_write(16'h4000, 8'h02);
    peek(16'hA123);
    check("R9 ram_addr", ram_addr, 15'h4123);
    check("R9 open read", cpu_rdata, 8'h77);
    cpu_wr = 1'b1; #1;
    check("R9 open we", ram_we, 1);
    cpu_wr = 1'b0;
    peek(16'hC000);
    check("R9 outside window", cpu_rdata, 8'hFF);

    // R7 size decode
    hdr_ram_code = 8'd0; #1; check("R7 code0", ram_size, 16'h0000);
    hdr_ram_code = 8'd1; #1; check("R7 code1", ram_size, 16'h0800);
    hdr_ram_code = 8'd2; #1; check("R7 code2", ram_size, 16'h2000);
    hdr_ram_code = 8'd3; #1; check("R7 code3", ram_size, 16'h8000);
    hdr_ram_code = 8'd5; #1; check("R7 unknown", ram_size, 16'h2000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule